// File: doc/BRIEF.md
# Overcurrent Pulse-Skip Controller with Threshold Fold-Back

This block protects the power switch of a switching regulator one cycle at a time. It watches a peak-current comparator flag during each on-time. The flag is ignored for a fixed blanking window at the start of the on-time, and the flag is sampled once, on the first clock after that window ends. An overcurrent at that sample removes the gate permit at once and raises an adaptive skip level by one. A clean sample lowers the skip level by one. After every sample, the block withholds the gate permit for as many following cycle-start pulses as the new skip level. With the level at its ceiling of seven, only one period in eight can switch.

A second, independent path chooses the peak-current threshold. When the feedback comparator reports the output below the fold level, the block selects a reduced threshold of one third of nominal. This reduction is held off while soft-start is running. Current sensing, threshold generation and the oscillator are outside the block. The surrounding PWM logic raises the switch-on indication only while the gate permit is high.

Top module: `ocp_skip_foldback`

## Requirements
- R1: For the first BLANK_CYCLES (default 12) clocks of each on-time, counted from the first clock where `sw_on` is high, a high `oc_flag` has no effect: `gate_ok` stays high.
- R2: If `oc_flag` is high on clock BLANK_CYCLES+1 of an on-time (the sample clock), `gate_ok` is low from the next clock and stays low at least until the next `cyc_start`.
- R3: A sample with `oc_flag` high raises the skip level by one.
- R4: A sample with `oc_flag` low lowers the skip level by one, and it never goes below zero.
- R5: After a sample leaves the skip level at N, the next N `cyc_start` pulses are skipped: `gate_ok` is low the clock after each of them. The `cyc_start` after those N pulses sets `gate_ok` high on the following clock.
- R6: The skip level saturates at SKIP_MAX (default 7). Under continuing overcurrent, exactly one period in eight is permitted.
- R7: A high `oc_flag` later in the on-time, after the sample clock, drops `gate_ok` on the next clock. It does not change the skip level.
- R8: An on-time that ends before its sample clock (BLANK_CYCLES clocks or fewer) leaves the skip level and the pending skips unchanged.
- R9: `ilim_sel` is registered. It is 1 (reduced threshold, one third of nominal) one clock after `fb_low`=1 with `ss_active`=0. It is 0 (nominal) one clock after `fb_low`=0.
- R10: `ss_active`=1 forces `ilim_sel` to 0 on the next clock, whatever `fb_low` is.
- R11: After reset, `gate_ok`=1, `ilim_sel`=0 and the skip level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (blanking is counted in these cycles) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | One-clock pulse at the start of each switching period |
| sw_on | input | 1 | High while the power switch is commanded on |
| oc_flag | input | 1 | Peak-current comparator: current above the threshold |
| fb_low | input | 1 | Feedback is below the fold level |
| ss_active | input | 1 | Soft-start is in progress |
| gate_ok | output | 1 | Gate permit; low means the switch must be off |
| ilim_sel | output | 1 | Threshold select: 0 nominal, 1 one-third |

## Verification
The assertions assume that `cyc_start` is a single-clock pulse and never coincides with `sw_on` being high. They also assume that `sw_on` rises only while `gate_ok` is high, as a PWM stage obeying the permit would behave. The bench keeps to this by building fixed-length periods. Each period opens with a `cyc_start` clock with the switch off. An on-time follows only when the permit is expected, and the switch is then off until the next period. The skip level is observed only through the count of suppressed periods that follows each sample.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  // Threshold choice handed to the current-limit reference generator.
  typedef enum logic {
    LIM_NOMINAL = 1'b0,
    LIM_REDUCED = 1'b1
  } lim_sel_e;

endpackage

// File: rtl/ocp_blank_timer.sv
// Counts the leading-edge blanking window of each on-time and marks the
// single clock on which the current flag is sampled.
module ocp_blank_timer #(
  parameter int BLANK_CYCLES = 12,
  localparam int BW = $clog2(BLANK_CYCLES + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_on,
  output logic smp_stb,
  output logic live_on
);

  logic [BW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          at_end;
  logic          tmr_en;

  assign at_end  = (cnt_q == BW'(BLANK_CYCLES));
  assign smp_stb = sw_on & ~done_q & at_end;
  assign live_on = sw_on & done_q;
  assign tmr_en  = sw_on | done_q | (cnt_q != '0);

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!sw_on) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (!done_q) begin
      if (at_end) begin
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (tmr_en) begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

endmodule

// File: rtl/ocp_skip_ctrl.sv
// Adaptive skip level and gate permit. The level moves by one on each
// sample; the pending-skip counter then withholds that many periods.
module ocp_skip_ctrl #(
  parameter int SKIP_MAX = 7,
  localparam int LVL_W = $clog2(SKIP_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start,
  input  logic             oc_flag,
  input  logic             smp_stb,
  input  logic             live_on,
  output logic             gate_ok,
  output logic [LVL_W-1:0] lvl
);

  localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(SKIP_MAX);

  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [LVL_W-1:0] rem_q, rem_d;
  logic             inh_q, inh_d;
  logic             upd_en;

  assign upd_en  = cyc_start | smp_stb | (live_on & oc_flag);
  assign gate_ok = ~inh_q;
  assign lvl     = lvl_q;

  always_comb begin
    lvl_d = lvl_q;
    rem_d = rem_q;
    inh_d = inh_q;
    if (smp_stb) begin
      if (oc_flag) begin
        lvl_d = (lvl_q == LVL_TOP) ? LVL_TOP : lvl_q + 1'b1;
        inh_d = 1'b1;
      end else begin
        lvl_d = (lvl_q == '0) ? '0 : lvl_q - 1'b1;
      end
      rem_d = lvl_d;
    end else if (live_on && oc_flag) begin
      inh_d = 1'b1;
    end
    if (cyc_start) begin
      if (rem_d != '0) begin
        rem_d = rem_d - 1'b1;
        inh_d = 1'b1;
      end else begin
        inh_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      rem_q <= '0;
      inh_q <= 1'b0;
    end else if (upd_en) begin
      lvl_q <= lvl_d;
      rem_q <= rem_d;
      inh_q <= inh_d;
    end
  end

endmodule

// File: rtl/ocp_fold_sel.sv
// Chooses the reduced current threshold while feedback sits below the
// fold level, except during soft-start.
module ocp_fold_sel
  import ocp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fb_low,
  input  logic     ss_active,
  output lim_sel_e sel
);

  lim_sel_e sel_q, sel_d;

  always_comb begin
    sel_d = (fb_low && !ss_active) ? LIM_REDUCED : LIM_NOMINAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= LIM_NOMINAL;
    end else begin
      sel_q <= sel_d;
    end
  end

  assign sel = sel_q;

endmodule

// File: rtl/ocp_skip_foldback.sv
module ocp_skip_foldback
  import ocp_pkg::*;
#(
  parameter int BLANK_CYCLES = 12,
  parameter int SKIP_MAX     = 7,
  localparam int LVL_W       = $clog2(SKIP_MAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic sw_on,
  input  logic oc_flag,
  input  logic fb_low,
  input  logic ss_active,
  output logic gate_ok,
  output logic ilim_sel
);

  logic             smp_stb;
  logic             live_on;
  logic [LVL_W-1:0] skip_lvl;
  lim_sel_e         lim_sel;

  ocp_blank_timer #(
    .BLANK_CYCLES(BLANK_CYCLES)
  ) u_blank (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_on   (sw_on),
    .smp_stb (smp_stb),
    .live_on (live_on)
  );

  ocp_skip_ctrl #(
    .SKIP_MAX(SKIP_MAX)
  ) u_skip (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_start (cyc_start),
    .oc_flag   (oc_flag),
    .smp_stb   (smp_stb),
    .live_on   (live_on),
    .gate_ok   (gate_ok),
    .lvl       (skip_lvl)
  );

  ocp_fold_sel u_fold (
    .clk       (clk),
    .rst_n     (rst_n),
    .fb_low    (fb_low),
    .ss_active (ss_active),
    .sel       (lim_sel)
  );

  assign ilim_sel = (lim_sel == LIM_REDUCED);

endmodule

// File: rtl/ocp_skip_foldback_chk.sv
module ocp_skip_foldback_chk #(
  parameter int SKIP_MAX = 7,
  parameter int LVL_W    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_start,
  input logic             oc_flag,
  input logic             fb_low,
  input logic             ss_active,
  input logic             gate_ok,
  input logic             ilim_sel,
  input logic             smp_stb,
  input logic             live_on,
  input logic [LVL_W-1:0] lvl
);

  assert_blank_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_ok && !cyc_start && !(oc_flag && (smp_stb || live_on))) |=> gate_ok);

  assert_cut_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && oc_flag && !cyc_start) |=> !gate_ok);

  assert_hold_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_ok && !cyc_start) |=> !gate_ok);

  assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && oc_flag && (lvl != LVL_W'(SKIP_MAX))) |=> (lvl == $past(lvl) + LVL_W'(1)));

  assert_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && !oc_flag && (lvl == '0)) |=> (lvl == '0));

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_ok) |-> $past(cyc_start));

  assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && oc_flag && (lvl == LVL_W'(SKIP_MAX))) |=> (lvl == LVL_W'(SKIP_MAX)));

  assert_level_still_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> $stable(lvl));

  assert_fold_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_low && !ss_active) |=> ilim_sel);

  assert_fold_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_low |=> !ilim_sel);

  assert_ss_nominal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ss_active |=> !ilim_sel);

endmodule

bind ocp_skip_foldback ocp_skip_foldback_chk #(
  .SKIP_MAX(SKIP_MAX),
  .LVL_W   (LVL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cyc_start (cyc_start),
  .oc_flag   (oc_flag),
  .fb_low    (fb_low),
  .ss_active (ss_active),
  .gate_ok   (gate_ok),
  .ilim_sel  (ilim_sel),
  .smp_stb   (smp_stb),
  .live_on   (live_on),
  .lvl       (skip_lvl)
);

// File: tb/ocp_skip_foldback_tb.sv
`timescale 1ns/1ps
module ocp_skip_foldback_tb;

  localparam int BLANK = 12;
  localparam int LMAX  = 7;
  localparam int PER   = 20;

  logic clk;
  logic rst_n;
  logic cyc_start, sw_on, oc_flag, fb_low, ss_active;
  logic gate_ok, ilim_sel;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  // bench-side expectation of skip level and pending skips
  int exp_lvl  = 0;
  int pend     = 0;
  bit fb_low_v = 0;
  bit ss_v     = 0;

  // scoreboard queues
  bit    q_g[$];
  bit    q_i[$];
  string q_gt[$];
  string q_it[$];

  ocp_skip_foldback #(.BLANK_CYCLES(BLANK), .SKIP_MAX(LMAX)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_start (cyc_start),
    .sw_on     (sw_on),
    .oc_flag   (oc_flag),
    .fb_low    (fb_low),
    .ss_active (ss_active),
    .gate_ok   (gate_ok),
    .ilim_sel  (ilim_sel)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // driver: apply one clock of inputs and queue what the next edge must give
  task automatic step(input bit cs, input bit on, input bit oc,
                      input bit exp_g, input string gtag);
    @(negedge clk);
    cyc_start = cs;
    sw_on     = on;
    oc_flag   = oc;
    fb_low    = fb_low_v;
    ss_active = ss_v;
    q_g.push_back(exp_g);
    q_gt.push_back(gtag);
    q_i.push_back(fb_low_v & ~ss_v);
    q_it.push_back(ss_v ? "R10" : "R9");
  endtask

  // monitor: compare just after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_g.size() > 0) begin
        bit    eg, ei;
        string tg, ti;
        eg = q_g.pop_front();
        ei = q_i.pop_front();
        tg = q_gt.pop_front();
        ti = q_it.pop_front();
        checks++;
        if (gate_ok !== eg) begin
          failures++;
          $display("FAIL %s gate_ok actual=%b expected=%b t=%0t", tg, gate_ok, eg, $time);
        end
        checks++;
        if (ilim_sel !== ei) begin
          failures++;
          $display("FAIL %s ilim_sel actual=%b expected=%b t=%0t", ti, ilim_sel, ei, $time);
        end
      end
    end
  end

  // one switching period; on_len on-clocks if permitted, oc high from oc_from
  task automatic run(input int on_len, input int oc_from, input string tag);
    bit    permit;
    int    ol;
    bit    cut;
    string t;
    permit = (pend == 0);
    ol     = permit ? on_len : 0;
    cut    = 0;
    step(1'b1, 1'b0, 1'b0, permit, permit ? tag : "R5");
    for (int i = 0; i < ol; i++) begin
      bit ocv;
      ocv = (i >= oc_from);
      if (ocv && i >= BLANK) cut = 1;
      if (ocv && i < BLANK) t = "R1";
      else if (cut && i > BLANK) t = "R7";
      else if (cut) t = "R2";
      else t = tag;
      step(1'b0, 1'b1, ocv, !cut, t);
    end
    for (int k = 1 + ol; k < PER; k++)
      step(1'b0, 1'b0, 1'b0, permit && !cut, permit ? (cut ? "R2" : tag) : "R5");
    if (!permit) begin
      pend--;
    end else if (ol > BLANK) begin
      if (oc_from <= BLANK) exp_lvl = (exp_lvl == LMAX) ? LMAX : exp_lvl + 1; // R3, R6
      else                  exp_lvl = (exp_lvl == 0) ? 0 : exp_lvl - 1;       // R4
      pend = exp_lvl;
    end
  endtask

  initial begin
    int hits;
    rst_n = 1'b0;
    cyc_start = 0; sw_on = 0; oc_flag = 0; fb_low = 0; ss_active = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    repeat (3) step(1'b0, 1'b0, 1'b0, 1'b1, "R11");
    run(16, 100, "R11");

    // R1 then R2: overcurrent during blanking is ignored, cut at the sample
    run(16, 0, "R1");
    // R3 and R6: climb to the ceiling and stay there
    hits = 1;
    while (hits < 10) begin
      if (pend == 0) hits++;
      run(16, 0, (exp_lvl == LMAX) ? "R6" : "R3");
    end
    // R6: one permitted period in eight at the ceiling
    for (int p = 0; p < 16; p++) run(16, 0, "R6");
    // R4: come down and hold at zero
    for (int p = 0; p < 40; p++) run(16, 100, "R4");

    // R7: raise to level 2, then late overcurrent only lowers by the sample
    run(16, 0, "R3");
    while (pend > 0) run(16, 0, "R5");
    run(16, 0, "R3");
    while (pend > 0) run(16, 0, "R5");
    run(16, 14, "R7");
    for (int p = 0; p < 4; p++) run(16, 100, "R7");

    // R8: short on-times with overcurrent leave level unchanged
    for (int p = 0; p < 3; p++) begin
      run(16, 0, "R3");
      while (pend > 0) run(16, 0, "R5");
    end
    run(BLANK, 0, "R8");
    run(5, 0, "R8");
    for (int p = 0; p < 8; p++) run(16, 100, "R8");

    // R9 and R10: threshold fold-back
    fb_low_v = 1; ss_v = 0;
    repeat (5) step(1'b0, 1'b0, 1'b0, 1'b1, "R9");
    ss_v = 1;
    repeat (5) step(1'b0, 1'b0, 1'b0, 1'b1, "R10");
    ss_v = 0;
    repeat (3) step(1'b0, 1'b0, 1'b0, 1'b1, "R9");
    fb_low_v = 0;
    repeat (3) step(1'b0, 1'b0, 1'b0, 1'b1, "R9");
    fb_low_v = 0; ss_v = 1;
    repeat (3) step(1'b0, 1'b0, 1'b0, 1'b1, "R10");
    ss_v = 0;
    // fold-back while switching at overcurrent
    fb_low_v = 1;
    for (int p = 0; p < 4; p++) run(16, 0, "R9");
    fb_low_v = 0;
    run(16, 100, "R9");

    repeat (3) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule